// File: doc/BRIEF.md
# Dual-compare 8-bit timer

This block is an 8-bit up-counter with two compare-constant registers, a selectable count source, a selectable clearing rule, three sticky status flags and a single timer output pin. Software reaches all state through a small synchronous register bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The bus has no handshake: every access completes in one cycle and cannot be stalled, so there is no back-pressure to manage.

The count advances on one of several internal prescaled tick inputs, or on edges of an external clock. The external clock passes through a two-flop synchroniser before an edge detector makes a one-cycle enable from it. The counter can be cleared by a match on either compare channel or by a rising edge on an external clear input, which is synchronised the same way. Each compare channel carries a 2-bit action that sets, clears or toggles the output pin when that channel matches.

Register map (byte-wide, 3-bit address):
- 0: count
- 1: compare A
- 2: compare B
- 3: mode, where bits [2:0] are the count source and bits [4:3] are the clear rule
- 4: output actions, where bits [1:0] are channel A and bits [3:2] are channel B
- 5: status, where bit 0 is match A, bit 1 is match B and bit 2 is overflow

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count reads 0x00, both compare registers read 0xFF, the mode, action and status registers read 0x00, and `tmr_out` is 0.
- R2: The count increases by one on each enabled clock cycle of the selected source. The mode bits [2:0] select the source: 000 stops the count, and 001 to 100 select `pre_tick[0]` to `pre_tick[3]`. A source tied low produces no counting.
- R3: Mode source codes 101, 110 and 111 count rising edges, falling edges, or both edges of `ext_clk`, after a two-flop synchroniser.
- R4: A count step from 0xFF to 0x00 sets status bit 2. This does not happen when a clear or a CPU write takes that cycle instead.
- R5: A match on a channel is the first cycle in which the count equals that channel's compare register. A match on channel A sets status bit 0, and a match on channel B sets status bit 1.
- R6: In a cycle where the bus writes a compare register, that channel produces no match.
- R7: The clear rule in mode bits [4:3] takes these values: 00 never clears, 01 clears on a match A and 10 clears on a match B. A clear sets the count to 0x00 at the next edge in place of counting.
- R8: Clear rule 11 clears the count after a synchronised rising edge of `ext_clr`. Under any other rule `ext_clr` has no effect.
- R9: A bus write to the count wins over both clearing and counting in the same cycle.
- R10: Each channel's 2-bit action is encoded as 00 = hold, 01 = drive low, 10 = drive high and 11 = toggle. When both channels match in the same cycle and channel A's action is not 00, channel A's action is used.
- R11: Status bits are sticky. Writing 0 to a bit clears it only if the bit was read as 1 since the last status write. Writing 1 leaves the bit unchanged. A set event in the same cycle beats the clear.
- R12: Registers read back through the map above. Unused bits of the mode, action and status registers read 0, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used to arm status clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pre_tick | input | NUM_TICKS | Internal prescaled count enables |
| ext_clk | input | 1 | Asynchronous external count clock |
| ext_clr | input | 1 | Asynchronous external counter clear |
| stat_flags | output | 3 | Status flags {overflow, match B, match A} |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench checks the exact count after a known number of enabled edges in each clear rule. A design that counted during a clear cycle, or that cleared on the wrong channel, ends on a different value. It writes a compare register in the very cycle its match would occur. A design without the suppression sets the match flag, which the bench reports. It sets up simultaneous matches with conflicting actions, so a design that gave channel B priority leaves the pin at the wrong level. It also writes status zeros without a prior read, which a design lacking the read-then-write rule would wrongly clear. A bus write to the count during counting shows whether the write wins, and `ext_clr` pulses under a non-external rule must leave the count untouched.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_MATCH_A = 2'b01,
    CLR_MATCH_B = 2'b10,
    CLR_EXT   = 2'b11
  } clr_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } out_act_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       pulse
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din};
  end

  logic rise, fall;
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

  always_comb begin
    unique case (edge_sel)
      2'b01:   pulse = rise;
      2'b10:   pulse = fall;
      2'b11:   pulse = rise | fall;
      default: pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cmp_wr,
  output logic             match
);
  logic eq, eq_q;
  assign eq = (cnt == cmp) && !cmp_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  assign match = eq && !eq_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_pkg::*;
#(
  parameter int NUM_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  clr_mode_e        clr_sel,
  input  logic [NUM_TICKS-1:0] pre_tick,
  input  logic             ext_pulse,
  input  logic             ext_clr_pulse,
  input  logic             match_a,
  input  logic             match_b,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_en,
  output logic             clr_now,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_en = 1'b0;
    if (src_sel >= 3'd5) cnt_en = ext_pulse;
    else begin
      for (int i = 0; i < NUM_TICKS; i++)
        if (src_sel == 3'(i + 1)) cnt_en = pre_tick[i];
    end
  end

  always_comb begin
    unique case (clr_sel)
      CLR_MATCH_A: clr_now = match_a;
      CLR_MATCH_B: clr_now = match_b;
      CLR_EXT:     clr_now = ext_clr_pulse;
      default:     clr_now = 1'b0;
    endcase
  end

  assign ovf_evt = cnt_en && !clr_now && !wr_cnt && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr_cnt)  cnt <= wdata;
    else if (clr_now) cnt <= '0;
    else if (cnt_en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_output.sv
module tmr_output
  import timer_pkg::*;
#(
  parameter logic OUT_INIT = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  out_act_e act_a,
  input  out_act_e act_b,
  input  logic     match_a,
  input  logic     match_b,
  output logic     pin
);
  out_act_e act;
  always_comb begin
    if (match_a && act_a != ACT_HOLD) act = act_a;
    else if (match_b)                 act = act_b;
    else                              act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= OUT_INIT;
    else begin
      unique case (act)
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        ACT_TOGGLE: pin <= ~pin;
        default:    pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [NFLAG-1:0]  set_flags,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic [2:0]        src_sel,
  output clr_mode_e         clr_sel,
  output logic [3:0]        act_bits,
  output logic [NFLAG-1:0]  flags,
  output logic              wr_cnt,
  output logic              wr_cmp_a,
  output logic              wr_cmp_b
);
  logic [NFLAG-1:0] armed_q;
  logic wr_mode, wr_act, wr_stat, rd_stat;

  assign wr_cnt   = bus_wr && bus_addr == A_CNT;
  assign wr_cmp_a = bus_wr && bus_addr == A_CMPA;
  assign wr_cmp_b = bus_wr && bus_addr == A_CMPB;
  assign wr_mode  = bus_wr && bus_addr == A_MODE;
  assign wr_act   = bus_wr && bus_addr == A_ACT;
  assign wr_stat  = bus_wr && bus_addr == A_STAT;
  assign rd_stat  = bus_rd && bus_addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a    <= '1;
      cmp_b    <= '1;
      src_sel  <= '0;
      clr_sel  <= CLR_NONE;
      act_bits <= '0;
    end else begin
      if (wr_cmp_a) cmp_a <= bus_wdata;
      if (wr_cmp_b) cmp_b <= bus_wdata;
      if (wr_mode) begin
        src_sel <= bus_wdata[2:0];
        clr_sel <= clr_mode_e'(bus_wdata[4:3]);
      end
      if (wr_act) act_bits <= bus_wdata[3:0];
    end
  end

  logic [NFLAG-1:0] flags_nxt;
  always_comb begin
    flags_nxt = flags;
    if (wr_stat) flags_nxt = flags & (bus_wdata[NFLAG-1:0] | ~armed_q);
    flags_nxt = flags_nxt | set_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      armed_q <= '0;
    end else begin
      flags <= flags_nxt;
      if (wr_stat)      armed_q <= '0;
      else if (rd_stat) armed_q <= armed_q | flags;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmp_a;
      A_CMPB:  bus_rdata = cmp_b;
      A_MODE:  bus_rdata = {3'b000, clr_sel, src_sel};
      A_ACT:   bus_rdata = {4'b0000, act_bits};
      A_STAT:  bus_rdata = {{(CNT_W-NFLAG){1'b0}}, flags};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import timer_pkg::*;
#(
  parameter int   NUM_TICKS   = 4,
  parameter int   SYNC_STAGES = 2,
  parameter logic OUT_INIT    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  input  logic [NUM_TICKS-1:0] pre_tick,
  input  logic                 ext_clk,
  input  logic                 ext_clr,
  output logic [NFLAG-1:0]     stat_flags,
  output logic                 tmr_out
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] cnt_q, cmp_a, cmp_b;
  logic [2:0]       src_sel;
  clr_mode_e        clr_sel;
  logic [3:0]       osel;
  logic             wr_cnt, wr_cmp_a, wr_cmp_b;
  logic             cnt_en, clr_now, ovf_evt;
  logic             ext_pulse, ext_clr_pulse;
  logic [NCH-1:0]   match_vec;
  logic             match_a, match_b;

  logic [CNT_W-1:0] cmp_arr [NCH];
  logic [NCH-1:0]   cmp_wr_vec;
  assign cmp_arr[0]  = cmp_a;
  assign cmp_arr[1]  = cmp_b;
  assign cmp_wr_vec  = {wr_cmp_b, wr_cmp_a};
  assign match_a     = match_vec[0];
  assign match_b     = match_vec[1];

  tmr_regs u_regs (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .cnt(cnt_q), .set_flags({ovf_evt, match_b, match_a}),
    .cmp_a, .cmp_b, .src_sel, .clr_sel, .act_bits(osel), .flags(stat_flags),
    .wr_cnt, .wr_cmp_a, .wr_cmp_b
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_clk (
    .clk, .rst_n, .din(ext_clk), .edge_sel(src_sel[1:0]), .pulse(ext_pulse)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_clr (
    .clk, .rst_n, .din(ext_clr), .edge_sel(2'b01), .pulse(ext_clr_pulse)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_match u_match (
      .clk, .rst_n, .cnt(cnt_q), .cmp(cmp_arr[ch]),
      .cmp_wr(cmp_wr_vec[ch]), .match(match_vec[ch])
    );
  end

  tmr_counter #(.NUM_TICKS(NUM_TICKS)) u_cnt (
    .clk, .rst_n, .src_sel, .clr_sel, .pre_tick, .ext_pulse, .ext_clr_pulse,
    .match_a, .match_b, .wr_cnt, .wdata(bus_wdata),
    .cnt(cnt_q), .cnt_en, .clr_now, .ovf_evt
  );

  tmr_output #(.OUT_INIT(OUT_INIT)) u_out (
    .clk, .rst_n, .act_a(out_act_e'(osel[1:0])), .act_b(out_act_e'(osel[3:2])),
    .match_a, .match_b, .pin(tmr_out)
  );
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] cnt,
  input logic [2:0] flags,
  input logic       match_a,
  input logic       match_b,
  input logic       cnt_en,
  input logic       clr_now,
  input logic [1:0] clr_sel,
  input logic [1:0] act_a,
  input logic       tmr_out
);
  a_r1_reset_count: assert property (@(posedge clk) !rst_n |=> cnt == 8'h00);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr_now && !(bus_wr && bus_addr == 3'd0)) |=> $stable(cnt));

  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == 8'hFF && !clr_now && !(bus_wr && bus_addr == 3'd0)) |=> flags[2]);

  a_r5_match_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flags[0]);

  a_r5_match_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> flags[1]);

  a_r6_write_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |-> !match_a);

  a_r7_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && clr_sel == 2'b01 && !(bus_wr && bus_addr == 3'd0)) |=> cnt == 8'h00);

  a_r9_cpu_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> cnt == $past(bus_wdata));

  a_r10_toggle_a: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && act_a == 2'b11) |=> tmr_out != $past(tmr_out));
endmodule

bind dual_cmp_timer dual_cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_q), .flags(stat_flags),
  .match_a(match_a), .match_b(match_b), .cnt_en(cnt_en), .clr_now(clr_now),
  .clr_sel(clr_sel), .act_a(osel[1:0]), .tmr_out(tmr_out)
);

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pre_tick = 4'b0101;
  logic ext_clk = 1'b0, ext_clr = 1'b0;
  logic [2:0] stat_flags;
  logic tmr_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer uut (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .pre_tick, .ext_clk, .ext_clr, .stat_flags, .tmr_out
  );

  typedef struct packed {
    logic [7:0] mode, cmpa, cmpb, start, run, expv;
  } vec_t;

  // mode byte = {3'b0, clear rule[1:0], source[2:0]}; run = enabled edges
  localparam vec_t VECS [8] = '{
    '{8'h01, 8'hFF, 8'hFF, 8'h0A, 8'd5,  8'h0F},  // R2 every cycle
    '{8'h00, 8'hFF, 8'hFF, 8'h0A, 8'd5,  8'h0A},  // R2 stopped
    '{8'h09, 8'h05, 8'hFF, 8'h00, 8'd8,  8'h02},  // R7 clear on A
    '{8'h11, 8'h03, 8'h07, 8'h00, 8'd10, 8'h02},  // R7 clear on B
    '{8'h01, 8'h03, 8'hFF, 8'hFE, 8'd4,  8'h02},  // R7 none, wraps
    '{8'h02, 8'hFF, 8'hFF, 8'h14, 8'd5,  8'h14},  // R2 tick tied low
    '{8'h03, 8'hFF, 8'hFF, 8'h28, 8'd3,  8'h2B},  // R2 tick tied high
    '{8'h19, 8'hFF, 8'hFF, 8'h80, 8'd6,  8'h86}   // R8 ext rule, no pulse
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // every bus task is entered and left at a falling edge
  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    rd(3'd5, d);
    wr(3'd5, 8'h00);
  endtask

  task automatic pulse_pin(ref logic p, input int n);
    for (int i = 0; i < n; i++) begin
      p = 1'b1; idle(3);
      p = 1'b0; idle(3);
    end
  endtask

  task automatic run_from(logic [7:0] mode, logic [7:0] start, int k);
    wr(3'd3, 8'h00);
    wr(3'd0, start);
    wr(3'd3, mode);
    idle(k);
    wr(3'd3, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 count", d, 8'h00);
    rd(3'd1, d); check("R1 cmpA", d, 8'hFF);
    rd(3'd2, d); check("R1 cmpB", d, 8'hFF);
    rd(3'd3, d); check("R1 mode", d, 8'h00);
    rd(3'd5, d); check("R1 status", d, 8'h00);
    check("R1 pin", {7'b0, tmr_out}, 8'h00);

    // vector table
    for (int v = 0; v < 8; v++) begin
      wr(3'd3, 8'h00);
      wr(3'd1, VECS[v].cmpa);
      wr(3'd2, VECS[v].cmpb);
      wr(3'd0, VECS[v].start);
      wr(3'd3, VECS[v].mode);
      idle(int'(VECS[v].run) - 1);
      wr(3'd3, 8'h00);
      rd(3'd0, d);
      check($sformatf("R2/R7 vector %0d", v), d, VECS[v].expv);
    end

    // R11 zero write without prior read is ignored; R4 overflow seen
    wr(3'd5, 8'h00);
    rd(3'd5, d); check("R11 sticky / R4 overflow", d, 8'h07);
    wr(3'd5, 8'h03);
    rd(3'd5, d); check("R11 partial clear", d, 8'h03);
    clear_flags();
    rd(3'd5, d); check("R11 full clear", d, 8'h00);

    // R6 compare write in the match cycle suppresses match A
    wr(3'd1, 8'h50);
    wr(3'd0, 8'h4F);
    wr(3'd3, 8'h01);
    idle(1);
    wr(3'd1, 8'h50);
    wr(3'd3, 8'h00);
    rd(3'd5, d); check("R6 suppressed", d, 8'h00);
    run_from(8'h01, 8'h4F, 2);
    rd(3'd5, d); check("R5 match A flag", d, 8'h01);
    clear_flags();

    // R10 A drives high, B drives low
    wr(3'd4, 8'h06);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h12);
    run_from(8'h01, 8'h0E, 2);
    check("R10 A high", {7'b0, tmr_out}, 8'h01);
    wr(3'd3, 8'h01); idle(1); wr(3'd3, 8'h00);
    check("R10 B low", {7'b0, tmr_out}, 8'h00);

    // R10 simultaneous: A toggle beats B high
    wr(3'd4, 8'h0B);
    wr(3'd1, 8'h20);
    wr(3'd2, 8'h20);
    run_from(8'h01, 8'h1E, 2);
    check("R10 both, first toggle", {7'b0, tmr_out}, 8'h01);
    run_from(8'h01, 8'h1E, 2);
    check("R10 both, A priority", {7'b0, tmr_out}, 8'h00);

    // R9 bus write to count beats counting
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h33);
    wr(3'd3, 8'h00);
    rd(3'd0, d); check("R9 write priority", d, 8'h34);

    // R3 external clock edges
    wr(3'd0, 8'h00); wr(3'd3, 8'h05);
    pulse_pin(ext_clk, 4); idle(4); wr(3'd3, 8'h00);
    rd(3'd0, d); check("R3 rising", d, 8'h04);
    wr(3'd0, 8'h00); wr(3'd3, 8'h06);
    pulse_pin(ext_clk, 4); idle(4); wr(3'd3, 8'h00);
    rd(3'd0, d); check("R3 falling", d, 8'h04);
    wr(3'd0, 8'h00); wr(3'd3, 8'h07);
    pulse_pin(ext_clk, 4); idle(4); wr(3'd3, 8'h00);
    rd(3'd0, d); check("R3 both edges", d, 8'h08);

    // R8 external clear only under rule 11
    wr(3'd3, 8'h18); wr(3'd0, 8'h77);
    pulse_pin(ext_clr, 1); idle(4);
    rd(3'd0, d); check("R8 ext clear", d, 8'h00);
    wr(3'd3, 8'h00); wr(3'd0, 8'h77);
    pulse_pin(ext_clr, 1); idle(4);
    rd(3'd0, d); check("R8 ext clear ignored", d, 8'h77);

    // R12 readback and masking
    wr(3'd3, 8'hFD);
    rd(3'd3, d); check("R12 mode", d, 8'h1D);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hF6);
    rd(3'd4, d); check("R12 action", d, 8'h06);
    rd(3'd6, d); check("R12 unmapped", d, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule